// File: doc/BRIEF.md
# VME A24 Slave Register Decoder

This block is the bus-side control engine of one multi-channel digitizer module that sits on a VME backplane. It watches the address strobe, data strobe, write line, address modifier and 24-bit address. It accepts only those A24/D16 cycles whose top address byte matches the module number set on an 8-bit switch. It turns each accepted data phase into a single-cycle action: clearing the channel FIFOs, clearing the zero-suppression thresholds, loading the sample count, writing one channel's threshold, or popping a word from one channel FIFO or from the merged FIFO stream.

Single cycles use modifier 0x3D. Block-transfer reads use modifier 0x3B or 0x3F. During a block read, an internal pointer walks round-robin across the channels, one word per data strobe, and a word counter records the length of the most recent block read so that software can read it back. A data-select code tells the external read mux which source drives the data bus. The data-transfer acknowledge is driven only after that code and any pop strobe are in place. The bus signals are resynchronised to the local clock by a configurable synchroniser chain.

Top module: `vme_reg_decoder`

## Requirements
- R1: A cycle is accepted only when address bits [23:16] equal `module_id`. A cycle to any other module gets no acknowledge, issues no strobe and leaves `sample_count` unchanged.
- R2: A single-cycle write (modifier 0x3D) to offset 0x0000 is a control write. Data bit 9 pulses `fifo_clr` and sets `fifo_ready`. Data bit 10 pulses `thr_clr`. Data bit 11 pulses `scnt_ld`. Any combination of these bits may fire in the same cycle.
- R3: `sample_count` is 1020 after reset. It changes only on a control write with data bit 11 set, and then takes data bits [9:0].
- R4: A single-cycle write to offset j*0x0100, with j from 1 to 32 and address bits [7:0] zero, pulses bit j-1 of `thr_we` for one cycle. No other bit of `thr_we` is set.
- R5: A single-cycle read at offset j*0x0100 (j from 1 to 32) gives one `pop` pulse with `pop_chan` = j-1, and `dsel` = 1 (channel FIFO).
- R6: A read at offset 0x0100 with modifier 0x3B or 0x3F is a merged block read, and `dsel` = 2. Each data strobe gives one `pop` pulse. `pop_chan` starts at 0 on every new address phase and steps by one per strobe, wrapping from 31 back to 0.
- R7: A read at offset 0x0101 with modifier 0x3B or 0x3F sets `dsel` = 3 and issues no pop. `blt_words` holds the number of data strobes in the most recent merged block read.
- R8: These cycles get neither an acknowledge nor a strobe: an unmatched modifier, a channel number of 0 or above 32, nonzero address bits [7:0] (apart from offset 0x0101), a read of offset 0x0000, or a write with a block-transfer modifier.
- R9: `vme_dtack_n` falls only after the strobe and `dsel` of the data phase are valid. It rises on the clock after the synchronised data strobe or address strobe is seen released.
- R10: Each accepted data phase issues exactly one action, and every strobe is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| module_id | input | 8 | Module number from the switch |
| vme_as_n | input | 1 | Address strobe, active low |
| vme_ds_n | input | 1 | Data strobe, active low |
| vme_write_n | input | 1 | Low for a write cycle |
| vme_am | input | 6 | Address modifier |
| vme_addr | input | 24 | Bus address |
| vme_data | input | 16 | Write data |
| vme_dtack_n | output | 1 | Data-transfer acknowledge, active low |
| dsel | output | 2 | Read source: 0 none, 1 channel FIFO, 2 merged FIFO, 3 word count |
| fifo_clr | output | 1 | Pulse: clear all channel FIFOs |
| fifo_ready | output | 1 | Set by a FIFO clear |
| thr_clr | output | 1 | Pulse: clear all thresholds |
| scnt_ld | output | 1 | Pulse: sample count loaded |
| sample_count | output | 10 | Current sample count |
| thr_we | output | 32 | One-hot threshold write strobe per channel |
| pop | output | 1 | Pulse: pop one FIFO word |
| pop_chan | output | 5 | Channel popped by `pop` |
| blt_words | output | 16 | Word count of the last merged block read |

## Verification
A latched cycle type that is wrong shows up within one data phase. It appears as a wrong `dsel` code at the acknowledge, or as a missing or extra acknowledge, or as a strobe of the wrong kind, which the scoreboard catches when it pops the next expected item. A block-read pointer that is stuck or is not cleared shows up as a wrong `pop_chan` at the second strobe of a block, or at the first strobe of the following block. A 35-word block also exercises the wrap past the last channel. Acknowledge timing faults are caught on every cycle: the bench measures the release latency and checks that the expected action has already been seen before the acknowledge falls.

// File: rtl/vme_reg_decoder_pkg.sv
package vme_reg_decoder_pkg;

   typedef enum logic [2:0] {
      CYC_NONE   = 3'd0,
      CYC_CTRL   = 3'd1,
      CYC_THR    = 3'd2,
      CYC_CHRD   = 3'd3,
      CYC_MERGED = 3'd4,
      CYC_COUNT  = 3'd5
   } cyc_kind_e;

   typedef enum logic [1:0] {
      DSEL_IDLE   = 2'd0,
      DSEL_CHAN   = 2'd1,
      DSEL_MERGED = 2'd2,
      DSEL_COUNT  = 2'd3
   } dsel_e;

   localparam logic [5:0] AM_SINGLE = 6'h3D;
   localparam logic [5:0] AM_BLK_A  = 6'h3B;
   localparam logic [5:0] AM_BLK_B  = 6'h3F;

   localparam int CTL_FIFO_BIT = 9;
   localparam int CTL_THR_BIT  = 10;
   localparam int CTL_SCNT_BIT = 11;

   localparam logic [15:0] OFF_MERGED = 16'h0100;
   localparam logic [15:0] OFF_COUNT  = 16'h0101;

endpackage

// File: rtl/vme_in_sync.sv
module vme_in_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 1) begin : g_single
         logic [W-1:0] r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '0;
            else        r_q <= d;
         end
         assign q = r_q;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
            end else begin
               pipe[0] <= d;
               for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/vme_addr_decode.sv
module vme_addr_decode
   import vme_reg_decoder_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int ID_W     = 8,
   parameter int NUM_CHAN = 32,
   parameter int CHAN_W   = 5
) (
   input  logic [ID_W-1:0]   module_id,
   input  logic [ADDR_W-1:0] addr,
   input  logic [5:0]        am,
   input  logic              wr,
   output cyc_kind_e         kind,
   output logic [CHAN_W-1:0] chan
);

   localparam int OFF_W = ADDR_W - ID_W;
   localparam int SEL_W = OFF_W - 8;

   logic [OFF_W-1:0] offset;
   logic [SEL_W-1:0] sel_field;
   logic [SEL_W-1:0] chan_m1;
   logic             id_hit;
   logic             am_single;
   logic             am_block;
   logic             chan_ok;

   assign offset    = addr[OFF_W-1:0];
   assign sel_field = offset[OFF_W-1:8];
   assign id_hit    = (addr[ADDR_W-1:OFF_W] == module_id);
   assign am_single = (am == AM_SINGLE);
   assign am_block  = (am == AM_BLK_A) || (am == AM_BLK_B);
   assign chan_ok   = (offset[7:0] == 8'h00) && (sel_field != '0) &&
                      (sel_field <= SEL_W'(NUM_CHAN));
   assign chan_m1   = sel_field - SEL_W'(1);
   assign chan      = chan_m1[CHAN_W-1:0];

   generate
      if (SEL_W > CHAN_W) begin : g_chan_spare
         logic unused_chan_hi;
         assign unused_chan_hi = ^chan_m1[SEL_W-1:CHAN_W];
      end
   endgenerate

   always_comb begin
      kind = CYC_NONE;
      if (id_hit) begin
         if (am_single && wr && offset == '0)
            kind = CYC_CTRL;
         else if (am_single && chan_ok)
            kind = wr ? CYC_THR : CYC_CHRD;
         else if (am_block && !wr && offset == OFF_W'(OFF_MERGED))
            kind = CYC_MERGED;
         else if (am_block && !wr && offset == OFF_W'(OFF_COUNT))
            kind = CYC_COUNT;
      end
   end

endmodule

// File: rtl/vme_cycle_fsm.sv
module vme_cycle_fsm
   import vme_reg_decoder_pkg::*;
#(
   parameter int CHAN_W    = 5,
   parameter int ACK_DELAY = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              as_s,
   input  logic              ds_s,
   input  cyc_kind_e         kind_in,
   input  logic [CHAN_W-1:0] chan_in,
   output cyc_kind_e         kind_q,
   output logic [CHAN_W-1:0] chan_q,
   output logic              addr_phase,
   output logic              dstart,
   output logic              dtack_n
);

   localparam int DLY_W = $clog2(ACK_DELAY + 1);

   typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WAIT, ST_ACK} st_e;

   st_e              state;
   logic             as_q;
   logic             ds_q;
   logic [DLY_W-1:0] dly;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         as_q       <= 1'b0;
         ds_q       <= 1'b0;
         dly        <= '0;
         kind_q     <= CYC_NONE;
         chan_q     <= '0;
         addr_phase <= 1'b0;
         dstart     <= 1'b0;
         dtack_n    <= 1'b1;
      end else begin
         as_q       <= as_s;
         ds_q       <= ds_s;
         addr_phase <= 1'b0;
         dstart     <= 1'b0;
         if (as_s && !as_q) begin
            kind_q     <= kind_in;
            chan_q     <= chan_in;
            addr_phase <= 1'b1;
            dtack_n    <= 1'b1;
            state      <= ST_ADDR;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_ADDR: begin
                  if (!as_s) state <= ST_IDLE;
                  else if (ds_s && !ds_q && kind_q != CYC_NONE) begin
                     dstart <= 1'b1;
                     dly    <= '0;
                     state  <= ST_WAIT;
                  end
               end
               ST_WAIT: begin
                  if (!ds_s || !as_s) state <= ST_ADDR;
                  else if (dly == DLY_W'(ACK_DELAY - 1)) begin
                     dtack_n <= 1'b0;
                     state   <= ST_ACK;
                  end else dly <= dly + DLY_W'(1);
               end
               ST_ACK: begin
                  if (!ds_s || !as_s) begin
                     dtack_n <= 1'b1;
                     state   <= ST_ADDR;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/vme_strobe_gen.sv
module vme_strobe_gen
   import vme_reg_decoder_pkg::*;
#(
   parameter int NUM_CHAN   = 32,
   parameter int CHAN_W     = 5,
   parameter int CTRL_W     = 12,
   parameter int SCNT_W     = 10,
   parameter int SCNT_RESET = 1020,
   parameter int WORDS_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  cyc_kind_e           kind_q,
   input  logic [CHAN_W-1:0]   chan_q,
   input  logic                addr_phase,
   input  logic                dstart,
   input  logic [CTRL_W-1:0]   data,
   output logic                fifo_clr,
   output logic                fifo_ready,
   output logic                thr_clr,
   output logic                scnt_ld,
   output logic [SCNT_W-1:0]   sample_count,
   output logic [NUM_CHAN-1:0] thr_we,
   output logic                pop,
   output logic [CHAN_W-1:0]   pop_chan,
   output logic [WORDS_W-1:0]  blt_words
);

   logic [CHAN_W-1:0] ptr;
   logic [CHAN_W-1:0] ptr_next;

   assign ptr_next = (ptr == CHAN_W'(NUM_CHAN - 1)) ? '0 : ptr + CHAN_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_clr     <= 1'b0;
         fifo_ready   <= 1'b0;
         thr_clr      <= 1'b0;
         scnt_ld      <= 1'b0;
         sample_count <= SCNT_W'(SCNT_RESET);
         pop          <= 1'b0;
         pop_chan     <= '0;
         ptr          <= '0;
         blt_words    <= '0;
      end else begin
         fifo_clr <= 1'b0;
         thr_clr  <= 1'b0;
         scnt_ld  <= 1'b0;
         pop      <= 1'b0;
         if (addr_phase) begin
            ptr <= '0;
            if (kind_q == CYC_MERGED) blt_words <= '0;
         end
         if (dstart) begin
            unique case (kind_q)
               CYC_CTRL: begin
                  fifo_clr <= data[CTL_FIFO_BIT];
                  thr_clr  <= data[CTL_THR_BIT];
                  scnt_ld  <= data[CTL_SCNT_BIT];
                  if (data[CTL_SCNT_BIT]) sample_count <= data[SCNT_W-1:0];
                  if (data[CTL_FIFO_BIT]) fifo_ready <= 1'b1;
               end
               CYC_CHRD: begin
                  pop      <= 1'b1;
                  pop_chan <= chan_q;
               end
               CYC_MERGED: begin
                  pop      <= 1'b1;
                  pop_chan <= ptr;
                  ptr      <= ptr_next;
                  if (blt_words != '1) blt_words <= blt_words + WORDS_W'(1);
               end
               default: ;
            endcase
         end
      end
   end

   generate
      for (genvar g = 0; g < NUM_CHAN; g++) begin : g_thr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) thr_we[g] <= 1'b0;
            else        thr_we[g] <= dstart && (kind_q == CYC_THR) &&
                                     (chan_q == CHAN_W'(g));
         end
      end
   endgenerate

endmodule

// File: rtl/vme_reg_decoder.sv
module vme_reg_decoder
   import vme_reg_decoder_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int DATA_W      = 16,
   parameter int ID_W        = 8,
   parameter int NUM_CHAN    = 32,
   parameter int SCNT_W      = 10,
   parameter int SCNT_RESET  = 1020,
   parameter int WORDS_W     = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ACK_DELAY   = 2,
   localparam int CHAN_W     = $clog2(NUM_CHAN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ID_W-1:0]     module_id,
   input  logic                vme_as_n,
   input  logic                vme_ds_n,
   input  logic                vme_write_n,
   input  logic [5:0]          vme_am,
   input  logic [ADDR_W-1:0]   vme_addr,
   input  logic [DATA_W-1:0]   vme_data,
   output logic                vme_dtack_n,
   output logic [1:0]          dsel,
   output logic                fifo_clr,
   output logic                fifo_ready,
   output logic                thr_clr,
   output logic                scnt_ld,
   output logic [SCNT_W-1:0]   sample_count,
   output logic [NUM_CHAN-1:0] thr_we,
   output logic                pop,
   output logic [CHAN_W-1:0]   pop_chan,
   output logic [WORDS_W-1:0]  blt_words
);

   localparam int CTRL_W = CTL_SCNT_BIT + 1;
   localparam int BUS_W  = 3 + 6 + ADDR_W + CTRL_W;

   generate
      if (NUM_CHAN < 2)                 begin : g_bad_chan  $error("NUM_CHAN below 2");            end
      if (ADDR_W - ID_W <= 8)           begin : g_bad_addr  $error("offset field too narrow");     end
      if (NUM_CHAN >= (1 << (ADDR_W - ID_W - 8)))
                                        begin : g_bad_sel   $error("channel field too narrow");   end
      if (DATA_W <= CTRL_W)             begin : g_bad_data  $error("data bus too narrow");        end
      if (SCNT_W > CTRL_W)              begin : g_bad_scnt  $error("sample count too wide");      end
      if (SCNT_RESET >= (1 << SCNT_W))  begin : g_bad_rst   $error("sample count reset too big"); end
      if (SYNC_STAGES < 1)              begin : g_bad_sync  $error("SYNC_STAGES below 1");         end
      if (ACK_DELAY < 1)                begin : g_bad_dly   $error("ACK_DELAY below 1");           end
   endgenerate

   logic [BUS_W-1:0]  sync_in;
   logic [BUS_W-1:0]  sync_out;
   logic              as_s;
   logic              ds_s;
   logic              wr_s;
   logic [5:0]        am_s;
   logic [ADDR_W-1:0] addr_s;
   logic [CTRL_W-1:0] data_s;
   logic              unused_data_hi;

   assign sync_in = {~vme_as_n, ~vme_ds_n, ~vme_write_n, vme_am, vme_addr,
                     vme_data[CTRL_W-1:0]};
   assign {as_s, ds_s, wr_s, am_s, addr_s, data_s} = sync_out;
   assign unused_data_hi = ^vme_data[DATA_W-1:CTRL_W];

   vme_in_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (sync_in),
      .q    (sync_out)
   );

   cyc_kind_e         kind_dec;
   logic [CHAN_W-1:0] chan_dec;

   vme_addr_decode #(
      .ADDR_W(ADDR_W), .ID_W(ID_W), .NUM_CHAN(NUM_CHAN), .CHAN_W(CHAN_W)
   ) u_dec (
      .module_id(module_id),
      .addr     (addr_s),
      .am       (am_s),
      .wr       (wr_s),
      .kind     (kind_dec),
      .chan     (chan_dec)
   );

   cyc_kind_e         kind_q;
   logic [CHAN_W-1:0] chan_q;
   logic              addr_phase;
   logic              dstart;
   logic              hit;

   vme_cycle_fsm #(.CHAN_W(CHAN_W), .ACK_DELAY(ACK_DELAY)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .as_s      (as_s),
      .ds_s      (ds_s),
      .kind_in   (kind_dec),
      .chan_in   (chan_dec),
      .kind_q    (kind_q),
      .chan_q    (chan_q),
      .addr_phase(addr_phase),
      .dstart    (dstart),
      .dtack_n   (vme_dtack_n)
   );

   assign hit = (kind_q != CYC_NONE);

   vme_strobe_gen #(
      .NUM_CHAN(NUM_CHAN), .CHAN_W(CHAN_W), .CTRL_W(CTRL_W), .SCNT_W(SCNT_W),
      .SCNT_RESET(SCNT_RESET), .WORDS_W(WORDS_W)
   ) u_stb (
      .clk         (clk),
      .rst_n       (rst_n),
      .kind_q      (kind_q),
      .chan_q      (chan_q),
      .addr_phase  (addr_phase),
      .dstart      (dstart),
      .data        (data_s),
      .fifo_clr    (fifo_clr),
      .fifo_ready  (fifo_ready),
      .thr_clr     (thr_clr),
      .scnt_ld     (scnt_ld),
      .sample_count(sample_count),
      .thr_we      (thr_we),
      .pop         (pop),
      .pop_chan    (pop_chan),
      .blt_words   (blt_words)
   );

   dsel_e dsel_v;

   always_comb begin
      unique case (kind_q)
         CYC_CHRD:   dsel_v = DSEL_CHAN;
         CYC_MERGED: dsel_v = DSEL_MERGED;
         CYC_COUNT:  dsel_v = DSEL_COUNT;
         default:    dsel_v = DSEL_IDLE;
      endcase
   end
   assign dsel = dsel_v;

endmodule

// File: rtl/vme_reg_decoder_chk.sv
module vme_reg_decoder_chk #(
   parameter int NUM_CHAN = 32,
   parameter int SCNT_W   = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                as_s,
   input logic                ds_s,
   input logic                hit,
   input logic                vme_dtack_n,
   input logic [1:0]          dsel,
   input logic                fifo_clr,
   input logic                thr_clr,
   input logic                scnt_ld,
   input logic [SCNT_W-1:0]   sample_count,
   input logic [NUM_CHAN-1:0] thr_we,
   input logic                pop
);

   // R9: acknowledge only inside an address phase
   p_ack_in_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !vme_dtack_n |-> as_s);

   // R9: released the clock after the data strobe goes away
   p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ds_s |=> vme_dtack_n);

   // R8: no acknowledge for an unmatched cycle
   p_no_ack_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> vme_dtack_n);

   // R4: at most one threshold strobe
   p_thr_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(thr_we));

   // R10: one action kind per data phase
   p_one_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fifo_clr | thr_clr | scnt_ld, |thr_we, pop}));

   // R10: pop is a single-cycle pulse
   p_pop_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> !pop);

   // R3: sample count moves only with its load strobe
   p_scnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !scnt_ld |-> $stable(sample_count));

   // R7: a count read never pops
   p_count_no_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dsel == 2'd3) |-> !pop);

endmodule

bind vme_reg_decoder vme_reg_decoder_chk #(.NUM_CHAN(NUM_CHAN), .SCNT_W(SCNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .as_s        (as_s),
   .ds_s        (ds_s),
   .hit         (hit),
   .vme_dtack_n (vme_dtack_n),
   .dsel        (dsel),
   .fifo_clr    (fifo_clr),
   .thr_clr     (thr_clr),
   .scnt_ld     (scnt_ld),
   .sample_count(sample_count),
   .thr_we      (thr_we),
   .pop         (pop)
);

// File: tb/test_vme_reg_decoder.sv
module test_vme_reg_decoder;

   localparam int NUM_CHAN = 32;
   localparam int SYNC     = 2;
   localparam logic [7:0] MY_ID = 8'h05;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                rst_n;
   logic                vme_as_n, vme_ds_n, vme_write_n;
   logic [5:0]          vme_am;
   logic [23:0]         vme_addr;
   logic [15:0]         vme_data;
   logic                vme_dtack_n;
   logic [1:0]          dsel;
   logic                fifo_clr, fifo_ready, thr_clr, scnt_ld, pop;
   logic [9:0]          sample_count;
   logic [NUM_CHAN-1:0] thr_we;
   logic [4:0]          pop_chan;
   logic [15:0]         blt_words;

   vme_reg_decoder i_vme_reg_decoder (
      .clk(clk), .rst_n(rst_n), .module_id(MY_ID),
      .vme_as_n(vme_as_n), .vme_ds_n(vme_ds_n), .vme_write_n(vme_write_n),
      .vme_am(vme_am), .vme_addr(vme_addr), .vme_data(vme_data),
      .vme_dtack_n(vme_dtack_n), .dsel(dsel), .fifo_clr(fifo_clr),
      .fifo_ready(fifo_ready), .thr_clr(thr_clr), .scnt_ld(scnt_ld),
      .sample_count(sample_count), .thr_we(thr_we), .pop(pop),
      .pop_chan(pop_chan), .blt_words(blt_words)
   );

   // event kinds: 1 control (ctl = {fifo,thr,scnt}), 2 threshold, 3 pop
   typedef struct packed {
      logic [1:0] ev;
      logic [4:0] chan;
      logic [2:0] ctl;
   } ev_t;

   ev_t   exp_q[$];
   string req_q[$];
   int    n_checks = 0;
   int    n_errors = 0;

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic expect_ev(logic [1:0] ev, int chan, logic [2:0] ctl, string req);
      exp_q.push_back('{ev: ev, chan: 5'(chan), ctl: ctl});
      req_q.push_back(req);
   endtask

   task automatic compare_obs(ev_t obs);
      ev_t   e;
      string r;
      if (exp_q.size() == 0) begin
         check(1'b0, "R8", "unexpected strobe", int'(obs), 0);
      end else begin
         e = exp_q.pop_front();
         r = req_q.pop_front();
         check(obs == e, r, "strobe item", int'(obs), int'(e));
      end
   endtask

   // monitor
   always @(negedge clk) begin
      ev_t obs;
      int  idx;
      if (rst_n) begin
         if (fifo_clr | thr_clr | scnt_ld) begin
            obs = '{ev: 2'd1, chan: 5'd0, ctl: {fifo_clr, thr_clr, scnt_ld}};
            compare_obs(obs);
         end
         if (|thr_we) begin
            idx = 0;
            for (int k = 0; k < NUM_CHAN; k++) if (thr_we[k]) idx = k;
            check($countones(thr_we) == 1, "R4", "thr_we one-hot", $countones(thr_we), 1);
            obs = '{ev: 2'd2, chan: 5'(idx), ctl: 3'b000};
            compare_obs(obs);
         end
         if (pop) begin
            obs = '{ev: 2'd3, chan: pop_chan, ctl: 3'b000};
            compare_obs(obs);
         end
      end
   end

   task automatic data_phase(bit exp_ack, string req, int exp_dsel);
      int waited;
      waited = 0;
      while (vme_dtack_n && waited < 20) begin @(negedge clk); waited++; end
      if (exp_ack) begin
         check(!vme_dtack_n, req, "dtack asserted", int'(vme_dtack_n), 0);
         if (!vme_dtack_n) begin
            check(exp_q.size() == 0, "R9", "action seen before ack", exp_q.size(), 0);
            check(int'(dsel) == exp_dsel, req, "dsel at ack", int'(dsel), exp_dsel);
         end
      end else begin
         check(vme_dtack_n, req, "no dtack on unmatched cycle", int'(vme_dtack_n), 1);
      end
      vme_ds_n = 1'b1;
      waited = 0;
      while (!vme_dtack_n && waited < 20) begin @(negedge clk); waited++; end
      if (exp_ack)
         check(vme_dtack_n && waited <= SYNC + 1, "R9", "dtack release latency",
               waited, SYNC + 1);
      @(negedge clk);
   endtask

   task automatic bus_cycle(logic [23:0] a, logic [5:0] am, bit wr, logic [15:0] d,
                            bit exp_ack, string req, int exp_dsel);
      @(negedge clk);
      vme_addr = a; vme_am = am; vme_write_n = ~wr; vme_data = d;
      repeat (2) @(negedge clk);
      vme_as_n = 1'b0;
      repeat (4) @(negedge clk);
      vme_ds_n = 1'b0;
      data_phase(exp_ack, req, exp_dsel);
      vme_as_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic blt_read(logic [5:0] am, int n);
      @(negedge clk);
      vme_addr = {MY_ID, 16'h0100}; vme_am = am; vme_write_n = 1'b1;
      repeat (2) @(negedge clk);
      vme_as_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int k = 0; k < n; k++) begin
         expect_ev(2'd3, k % NUM_CHAN, 3'b000, "R6");
         vme_ds_n = 1'b0;
         data_phase(1'b1, "R6", 2);
      end
      vme_as_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0;
      vme_as_n = 1'b1; vme_ds_n = 1'b1; vme_write_n = 1'b1;
      vme_am = '0; vme_addr = '0; vme_data = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check(vme_dtack_n == 1'b1, "R9", "dtack idle after reset", int'(vme_dtack_n), 1);
      check(sample_count == 10'd1020, "R3", "sample count reset", sample_count, 1020);
      check(fifo_ready == 1'b0, "R2", "ready after reset", int'(fifo_ready), 0);
      check(blt_words == 16'd0, "R7", "word count reset", blt_words, 0);

      // R2: FIFO clear only
      expect_ev(2'd1, 0, 3'b100, "R2");
      bus_cycle({MY_ID, 16'h0000}, 6'h3D, 1'b1, 16'h0200, 1'b1, "R2", 0);
      check(fifo_ready == 1'b1, "R2", "ready set by FIFO clear", int'(fifo_ready), 1);
      check(sample_count == 10'd1020, "R3", "count kept without bit 11", sample_count, 1020);

      // R2/R3: threshold clear and count load together
      expect_ev(2'd1, 0, 3'b011, "R2");
      bus_cycle({MY_ID, 16'h0000}, 6'h3D, 1'b1, 16'h0C00 | 16'd300, 1'b1, "R2", 0);
      check(sample_count == 10'd300, "R3", "sample count loaded", sample_count, 300);

      // R1: other module
      bus_cycle({MY_ID + 8'd1, 16'h0000}, 6'h3D, 1'b1, 16'h0800 | 16'd5, 1'b0, "R1", 0);
      check(sample_count == 10'd300, "R1", "count untouched by other module", sample_count, 300);

      // R4: threshold writes
      expect_ev(2'd2, 0, 3'b000, "R4");
      bus_cycle({MY_ID, 16'h0100}, 6'h3D, 1'b1, 16'h0011, 1'b1, "R4", 0);
      expect_ev(2'd2, 16, 3'b000, "R4");
      bus_cycle({MY_ID, 16'h1100}, 6'h3D, 1'b1, 16'h0022, 1'b1, "R4", 0);
      expect_ev(2'd2, 31, 3'b000, "R4");
      bus_cycle({MY_ID, 16'h2000}, 6'h3D, 1'b1, 16'h0033, 1'b1, "R4", 0);

      // R5: single channel reads
      expect_ev(2'd3, 0, 3'b000, "R5");
      bus_cycle({MY_ID, 16'h0100}, 6'h3D, 1'b0, 16'h0000, 1'b1, "R5", 1);
      expect_ev(2'd3, 31, 3'b000, "R5");
      bus_cycle({MY_ID, 16'h2000}, 6'h3D, 1'b0, 16'h0000, 1'b1, "R5", 1);

      // R8: unmatched cycles
      bus_cycle({MY_ID, 16'h2100}, 6'h3D, 1'b1, 16'h0001, 1'b0, "R8", 0);
      bus_cycle({MY_ID, 16'h0000}, 6'h3D, 1'b0, 16'h0000, 1'b0, "R8", 0);
      bus_cycle({MY_ID, 16'h0180}, 6'h3D, 1'b0, 16'h0000, 1'b0, "R8", 0);
      bus_cycle({MY_ID, 16'h0100}, 6'h3B, 1'b1, 16'h0000, 1'b0, "R8", 0);
      bus_cycle({MY_ID, 16'h0000}, 6'h39, 1'b1, 16'h0800, 1'b0, "R8", 0);
      check(sample_count == 10'd300, "R8", "count untouched by bad modifier", sample_count, 300);

      // R6: merged block read with wrap
      blt_read(6'h3B, 35);
      check(blt_words == 16'd35, "R7", "word count after 35-word block", blt_words, 35);

      // R7: count read
      bus_cycle({MY_ID, 16'h0101}, 6'h3F, 1'b0, 16'h0000, 1'b1, "R7", 3);
      check(blt_words == 16'd35, "R7", "word count kept over count read", blt_words, 35);

      // R6: pointer restarts on a new address phase
      blt_read(6'h3F, 3);
      check(blt_words == 16'd3, "R7", "word count after 3-word block", blt_words, 3);

      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, "R10", "all expected strobes seen", exp_q.size(), 0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R9: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule